// File: doc/BRIEF.md
# CAN Card Interrupt Bridge Glue

This block is the glue logic for a single-channel CAN controller card that sits behind a PCI-style host bridge. The host reaches three separate register windows through one simple request port. The first is a bridge window that holds an interrupt control and status register. The second is a byte-wide window that passes accesses through to the external CAN controller's register file. The third is a small board window that holds a read-only version byte. Every request gets exactly one response, two cycles later. An access with the wrong size, a misaligned address or an unknown window returns an error flag, and its write has no effect.

The CAN controller's level-sensitive interrupt request is sampled into a pending flag. That flag can always be read back through the status register. The host interrupt line is the pending flag gated by an enable bit that software controls. If software sets the enable while a request is already waiting, the line rises at once. Clearing the enable, or dropping the request, lowers the line on the next clock. After reset, the block holds the controller in hardware reset for a programmable number of cycles.

Top module: `can_irq_glue`

## Requirements
- R1: During reset and afterwards, the status register reads 0, `host_irq` and `rsp_valid` are low, and `can_rst` is high. `can_rst` stays high until the RST_PULSE-th rising clock edge after reset is released, and it is low from then on.
- R2: A request accepted on a rising edge, with `req_valid` high, produces `rsp_valid` high for exactly one cycle. This happens in the second cycle after the request cycle. `rsp_valid` is low in the cycle between them.
- R3: Window selection uses `req_win`: 0 is the bridge, 1 is CAN, 2 is the board and 3 is unused. Size selection uses `req_size`: 0 is byte, 1 is half, 2 is word and 3 is reserved. In the bridge window, only word accesses with `req_addr[1:0]` equal to 0 are legal; any other access sets `rsp_err`, reads 0 and writes nothing. Bridge offsets other than 0x38 read 0 and ignore writes.
- R4: The interrupt control/status register sits at bridge offset 0x38. A write stores all 32 bits, and a read returns them. Bit 13 is the interrupt enable.
- R5: On a read of the status register, bit 23 gives the pending state of the CAN request, whatever was last written to that bit.
- R6: When `can_irq` is high on a rising edge, the pending flag sets on that edge. `host_irq` is high after that edge only if the enable is set.
- R7: When `can_irq` is low on a rising edge, the pending flag clears on that edge and `host_irq` is low after it.
- R8: A write that sets the enable while a request is pending raises `host_irq` in the same cycle as the write's response.
- R9: A write that clears the enable lowers `host_irq` in the same cycle as the write's response, even while the request is still pending.
- R10: A byte access to a CAN-window offset below CAN_SPAN drives `can_cs` in the cycle after the request. In that cycle `can_addr` equals the offset, and `can_we` and `can_wdata` follow the request. A read returns `can_rdata` in bits 7:0 of the response.
- R11: CAN-window offsets at or above CAN_SPAN produce no strobe and read 0 without an error. Non-byte CAN accesses produce no strobe and set `rsp_err`.
- R12: Board-window offset 7 reads {VERSION, 4'h0} in bits 7:0, and all other offsets read 0. Writes are ignored. Non-byte accesses, and offsets at or above 8, set `rsp_err`.
- R13: A request to window 3 sets `rsp_err` and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe, one cycle per access |
| req_win | input | 2 | Window select |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data (bytes in bits 7:0) |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Illegal size, alignment, offset or window |
| can_irq | input | 1 | Level interrupt request from the CAN controller |
| host_irq | output | 1 | Level interrupt line to the host |
| can_rst | output | 1 | Hardware reset to the CAN controller |
| can_cs | output | 1 | Controller register access strobe |
| can_we | output | 1 | Controller write enable |
| can_addr | output | CAN_AW | Controller register offset |
| can_wdata | output | 8 | Controller write byte |
| can_rdata | input | 8 | Controller read byte, valid while `can_cs` is high |

## Verification
The bench keeps the default window geometry: a CAN span of 0x20, an 8-byte board window and version 0xD. With these values, aliasing across the span boundary shows up directly. Offsets 0x20 and 0x25 would fold onto 0x00 and 0x05, which hold different model contents. The bench shortens RST_PULSE to 4, so the whole reset pulse and its falling edge can be checked cycle by cycle. The interrupt sequences toggle the request and the enable in each order, so the one-cycle response of the line to every cause can be compared against the expected cycle.

// File: rtl/can_glue_pkg.sv
package can_glue_pkg;

  typedef enum logic [1:0] {
    WIN_BRIDGE = 2'd0,
    WIN_CAN    = 2'd1,
    WIN_BOARD  = 2'd2,
    WIN_NONE   = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic        valid;
    win_e        win;
    logic        we;
    size_e       size;
    logic [31:0] wdata;
  } acc_t;

endpackage

// File: rtl/cgl_irq_csr.sv
module cgl_irq_csr
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CSR_OFF  = 'h38,
  parameter int unsigned EN_BIT   = 13,
  parameter int unsigned PEND_BIT = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  size_e             size,
  input  logic [31:0]       wdata,
  input  logic              can_irq,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              host_irq
);

  logic [31:0] csr_q;
  logic        pend_q;
  logic        host_irq_q;
  logic        fmt_ok, hit, wr, en_next;
  logic [31:0] view;

  assign fmt_ok  = (size == SZ_WORD) && (addr[1:0] == 2'b00);
  assign err     = sel && !fmt_ok;
  assign hit     = sel && fmt_ok && (addr == CSR_OFF[ADDR_W-1:0]);
  assign wr      = hit && we;
  assign en_next = wr ? wdata[EN_BIT] : csr_q[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q      <= '0;
      pend_q     <= 1'b0;
      host_irq_q <= 1'b0;
    end else begin
      if (wr) csr_q <= wdata;
      pend_q     <= can_irq;
      host_irq_q <= can_irq && en_next;
    end
  end

  always_comb begin
    view           = csr_q;
    view[PEND_BIT] = pend_q;
  end

  assign rdata    = (hit && !we) ? view : '0;
  assign host_irq = host_irq_q;

  // R6: a live request with the enable held raises the line after one edge
  a_r6_raise: assert property (@(posedge clk) disable iff (rst)
    (can_irq && csr_q[EN_BIT] && !wr) |=> host_irq);

  // R7: a dropped request lowers the line after one edge
  a_r7_drop: assert property (@(posedge clk) disable iff (rst)
    !can_irq |=> !host_irq);

  // R8: enabling while a request waits raises the line at once
  a_r8_late_enable: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[EN_BIT] && can_irq) |=> host_irq);

  // R9: disabling lowers the line on the next edge
  a_r9_disable: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[EN_BIT]) |=> !host_irq);

endmodule

// File: rtl/cgl_can_port.sv
module cgl_can_port
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned CAN_SPAN = 32,
  parameter int unsigned CAN_AW   = 5
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  size_e             size,
  input  logic [7:0]        wdata,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              can_cs,
  output logic              can_we,
  output logic [CAN_AW-1:0] can_addr,
  output logic [7:0]        can_wdata,
  input  logic [7:0]        can_rdata
);

  logic fmt_ok, in_span, hit;

  assign fmt_ok    = (size == SZ_BYTE);
  assign in_span   = (32'(addr) < CAN_SPAN);
  assign err       = sel && !fmt_ok;
  assign hit       = sel && fmt_ok && in_span;

  assign can_cs    = hit;
  assign can_we    = hit && we;
  assign can_addr  = addr[CAN_AW-1:0];
  assign can_wdata = wdata;
  assign rdata     = (hit && !we) ? {24'b0, can_rdata} : '0;

endmodule

// File: rtl/cgl_board_regs.sv
module cgl_board_regs
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned BOARD_SPAN = 8,
  parameter int unsigned VER_OFF    = 7,
  parameter logic [3:0]  VERSION    = 4'hD
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  size_e             size,
  output logic [31:0]       rdata,
  output logic              err
);

  logic bad;

  assign bad   = (size != SZ_BYTE) || (32'(addr) >= BOARD_SPAN);
  assign err   = sel && bad;
  assign rdata = (sel && !bad && !we && (32'(addr) == VER_OFF))
                 ? {24'b0, VERSION, 4'b0000} : '0;

endmodule

// File: rtl/can_irq_glue.sv
module can_irq_glue
  import can_glue_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned CAN_SPAN   = 32,
  parameter int unsigned CAN_AW     = $clog2(CAN_SPAN),
  parameter int unsigned BOARD_SPAN = 8,
  parameter int unsigned VER_OFF    = 7,
  parameter logic [3:0]  VERSION    = 4'hD,
  parameter int unsigned CSR_OFF    = 'h38,
  parameter int unsigned EN_BIT     = 13,
  parameter int unsigned PEND_BIT   = 23,
  parameter int unsigned RST_PULSE  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_win,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              can_irq,
  output logic              host_irq,
  output logic              can_rst,
  output logic              can_cs,
  output logic              can_we,
  output logic [CAN_AW-1:0] can_addr,
  output logic [7:0]        can_wdata,
  input  logic [7:0]        can_rdata
);

  localparam int unsigned RST_CW = $clog2(RST_PULSE + 1);

  // stage 1: registered request
  acc_t              s1;
  logic [ADDR_W-1:0] s1_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= '0;
      s1_addr <= '0;
    end else begin
      s1.valid <= req_valid;
      s1.win   <= win_e'(req_win);
      s1.we    <= req_we;
      s1.size  <= size_e'(req_size);
      s1.wdata <= req_wdata;
      s1_addr  <= req_addr;
    end
  end

  logic        sel_br, sel_can, sel_bd, sel_none;
  logic [31:0] rd_br, rd_can, rd_bd;
  logic        er_br, er_can, er_bd;

  assign sel_br   = s1.valid && (s1.win == WIN_BRIDGE);
  assign sel_can  = s1.valid && (s1.win == WIN_CAN);
  assign sel_bd   = s1.valid && (s1.win == WIN_BOARD);
  assign sel_none = s1.valid && (s1.win == WIN_NONE);

  cgl_irq_csr #(
    .ADDR_W(ADDR_W), .CSR_OFF(CSR_OFF), .EN_BIT(EN_BIT), .PEND_BIT(PEND_BIT)
  ) u_csr (
    .clk(clk), .rst(rst), .sel(sel_br), .we(s1.we), .addr(s1_addr),
    .size(s1.size), .wdata(s1.wdata), .can_irq(can_irq),
    .rdata(rd_br), .err(er_br), .host_irq(host_irq)
  );

  cgl_can_port #(
    .ADDR_W(ADDR_W), .CAN_SPAN(CAN_SPAN), .CAN_AW(CAN_AW)
  ) u_can (
    .sel(sel_can), .we(s1.we), .addr(s1_addr), .size(s1.size),
    .wdata(s1.wdata[7:0]), .rdata(rd_can), .err(er_can),
    .can_cs(can_cs), .can_we(can_we), .can_addr(can_addr),
    .can_wdata(can_wdata), .can_rdata(can_rdata)
  );

  cgl_board_regs #(
    .ADDR_W(ADDR_W), .BOARD_SPAN(BOARD_SPAN), .VER_OFF(VER_OFF), .VERSION(VERSION)
  ) u_board (
    .sel(sel_bd), .we(s1.we), .addr(s1_addr), .size(s1.size),
    .rdata(rd_bd), .err(er_bd)
  );

  // stage 2: registered response
  logic        rsp_valid_q, rsp_err_q;
  logic [31:0] rsp_rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= s1.valid;
      rsp_err_q   <= er_br || er_can || er_bd || sel_none;
      rsp_rdata_q <= rd_br | rd_can | rd_bd;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // controller reset pulse
  logic [RST_CW-1:0] rst_cnt;
  logic              can_rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_cnt   <= RST_CW'(RST_PULSE);
      can_rst_q <= 1'b1;
    end else if (rst_cnt != '0) begin
      rst_cnt   <= rst_cnt - 1'b1;
      can_rst_q <= (rst_cnt > RST_CW'(1));
    end else begin
      can_rst_q <= 1'b0;
    end
  end

  assign can_rst = can_rst_q;

  // R1: once released, the controller reset never comes back
  a_r1_pulse_once: assert property (@(posedge clk) disable iff (rst)
    !can_rst |=> !can_rst);

  // R2: every request answers two cycles later, and nothing else does
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ##1 rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ##1 !rsp_valid);

  // R10: an in-span byte access strobes the controller at its offset
  a_r10_strobe: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_win == WIN_CAN && req_size == SZ_BYTE &&
     32'(req_addr) < CAN_SPAN)
    |=> (can_cs && can_addr == $past(req_addr[CAN_AW-1:0])));

  // R11: offsets past the span never reach the controller
  a_r11_no_alias: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_win == WIN_CAN && 32'(req_addr) >= CAN_SPAN) |=> !can_cs);

  // R13: the unused window errors with zero data
  a_r13_bad_window: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_win == WIN_NONE) |=> ##1 (rsp_err && rsp_rdata == '0));

endmodule

// File: tb/can_irq_glue_tb.sv
module can_irq_glue_tb;

  localparam int RST_P = 4;
  localparam logic [1:0] WB = 2'd0, WC = 2'd1, WD = 2'd2, WN = 2'd3;
  localparam logic [1:0] SB = 2'd0, SW = 2'd2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_win = '0;
  logic        req_we = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        can_irq = 1'b0;
  logic        host_irq, can_rst, can_cs, can_we;
  logic [4:0]  can_addr;
  logic [7:0]  can_wdata, can_rdata;

  int checks = 0;
  int errors = 0;
  int strobes = 0;

  always #5 clk = ~clk;

  can_irq_glue #(.RST_PULSE(RST_P)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_win(req_win),
    .req_we(req_we), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .can_irq(can_irq), .host_irq(host_irq),
    .can_rst(can_rst), .can_cs(can_cs), .can_we(can_we),
    .can_addr(can_addr), .can_wdata(can_wdata), .can_rdata(can_rdata)
  );

  // controller register file model
  logic [7:0] cmem [32];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) cmem[i] <= 8'h70 + 8'(i);
    end else if (can_cs && can_we) begin
      cmem[can_addr] <= can_wdata;
    end
  end
  assign can_rdata = cmem[can_addr];

  always @(posedge clk) if (!rst && can_cs) strobes <= strobes + 1;

  typedef struct packed {
    logic [1:0]  win;
    logic        we;
    logic [6:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    '{WB, 1'b0, 7'h38, SW, 32'h0,         32'h0,       1'b0, 4'd1},  // R1 status clear
    '{WB, 1'b1, 7'h38, SW, 32'h0080_2001, 32'h0,       1'b0, 4'd4},  // R4 write
    '{WB, 1'b0, 7'h38, SW, 32'h0,         32'h2001,    1'b0, 4'd5},  // R5 bit 23 hidden
    '{WB, 1'b1, 7'h10, SW, 32'hFFFF_FFFF, 32'h0,       1'b0, 4'd3},  // R3 other offset
    '{WB, 1'b0, 7'h10, SW, 32'h0,         32'h0,       1'b0, 4'd3},  // R3
    '{WB, 1'b0, 7'h38, SW, 32'h0,         32'h2001,    1'b0, 4'd3},  // R3 untouched
    '{WB, 1'b1, 7'h38, SB, 32'h0,         32'h0,       1'b1, 4'd3},  // R3 byte rejected
    '{WB, 1'b0, 7'h38, SW, 32'h0,         32'h2001,    1'b0, 4'd3},  // R3 no write
    '{WB, 1'b0, 7'h3A, SW, 32'h0,         32'h0,       1'b1, 4'd3},  // R3 misaligned
    '{WC, 1'b1, 7'h05, SB, 32'hA5,        32'h0,       1'b0, 4'd10}, // R10
    '{WC, 1'b0, 7'h05, SB, 32'h0,         32'hA5,      1'b0, 4'd10}, // R10
    '{WC, 1'b1, 7'h1F, SB, 32'h3C,        32'h0,       1'b0, 4'd10}, // R10 last offset
    '{WC, 1'b0, 7'h1F, SB, 32'h0,         32'h3C,      1'b0, 4'd10}, // R10
    '{WC, 1'b1, 7'h25, SB, 32'h11,        32'h0,       1'b0, 4'd11}, // R11 dropped
    '{WC, 1'b0, 7'h05, SB, 32'h0,         32'hA5,      1'b0, 4'd11}, // R11 no alias
    '{WC, 1'b0, 7'h25, SB, 32'h0,         32'h0,       1'b0, 4'd11}, // R11
    '{WC, 1'b0, 7'h20, SB, 32'h0,         32'h0,       1'b0, 4'd11}, // R11 boundary
    '{WC, 1'b1, 7'h05, SW, 32'h99,        32'h0,       1'b1, 4'd11}, // R11 word rejected
    '{WC, 1'b0, 7'h05, SB, 32'h0,         32'hA5,      1'b0, 4'd11}, // R11
    '{WD, 1'b0, 7'h07, SB, 32'h0,         32'hD0,      1'b0, 4'd12}, // R12 version
    '{WD, 1'b0, 7'h06, SB, 32'h0,         32'h0,       1'b0, 4'd12}, // R12
    '{WD, 1'b1, 7'h07, SB, 32'hFF,        32'h0,       1'b0, 4'd12}, // R12 write
    '{WD, 1'b0, 7'h07, SB, 32'h0,         32'hD0,      1'b0, 4'd12}, // R12 ignored
    '{WD, 1'b0, 7'h07, SW, 32'h0,         32'h0,       1'b1, 4'd12}, // R12 size
    '{WD, 1'b0, 7'h08, SB, 32'h0,         32'h0,       1'b1, 4'd12}, // R12 range
    '{WN, 1'b0, 7'h00, SB, 32'h0,         32'h0,       1'b1, 4'd13}  // R13
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] w, input logic we, input logic [6:0] a,
                        input logic [1:0] sz, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er,
                        output logic irq_mid, output logic irq_end);
    @(negedge clk);
    req_valid = 1'b1; req_win = w; req_we = we; req_addr = a;
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    irq_mid = host_irq;
    chk("R2 no early response", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk("R2 response strobe", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
    er = rsp_err;
    irq_end = host_irq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er, im, ie;

    repeat (4) @(negedge clk);
    chk("R1 can_rst in reset", {31'b0, can_rst}, 32'd1);
    rst = 1'b0;
    for (int k = 1; k <= RST_P; k++) begin
      @(negedge clk);
      chk($sformatf("R1 can_rst edge %0d", k), {31'b0, can_rst}, (k < RST_P) ? 32'd1 : 32'd0);
    end
    chk("R1 host_irq low", {31'b0, host_irq}, 32'd0);
    chk("R1 rsp_valid low", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VT[i].win, VT[i].we, VT[i].addr, VT[i].size, VT[i].wdata, rd, er, im, ie);
      chk($sformatf("R%0d row %0d rdata", VT[i].req, i), rd, VT[i].exp_rd);
      chk($sformatf("R%0d row %0d err", VT[i].req, i), {31'b0, er}, {31'b0, VT[i].exp_err});
    end
    chk("R11 strobe count", strobes, 32'd6);

    // interrupt sequences
    access(WB, 1'b1, 7'h38, SW, 32'h0, rd, er, im, ie);
    can_irq = 1'b1;
    @(negedge clk);
    chk("R6 gated while disabled", {31'b0, host_irq}, 32'd0);
    access(WB, 1'b0, 7'h38, SW, 32'h0, rd, er, im, ie);
    chk("R5 pending visible", rd, 32'h0080_0000);
    access(WB, 1'b1, 7'h38, SW, 32'h2000, rd, er, im, ie);
    chk("R8 line low before write lands", {31'b0, im}, 32'd0);
    chk("R8 line high with response", {31'b0, ie}, 32'd1);
    can_irq = 1'b0;
    @(negedge clk);
    chk("R7 line drops", {31'b0, host_irq}, 32'd0);
    access(WB, 1'b0, 7'h38, SW, 32'h0, rd, er, im, ie);
    chk("R7 pending cleared", rd, 32'h2000);
    can_irq = 1'b1;
    @(negedge clk);
    chk("R6 line follows request", {31'b0, host_irq}, 32'd1);
    access(WB, 1'b1, 7'h38, SW, 32'h0, rd, er, im, ie);
    chk("R9 line held until write lands", {31'b0, im}, 32'd1);
    chk("R9 line low with response", {31'b0, ie}, 32'd0);
    access(WB, 1'b0, 7'h38, SW, 32'h0, rd, er, im, ie);
    chk("R5 pending with enable off", rd, 32'h0080_0000);
    can_irq = 1'b0;
    @(negedge clk);
    chk("R7 line stays low", {31'b0, host_irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule